// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the network-layer controller of a 1-Wire slave that owns a 64-bit identity code. It sits above a separate bit-timing layer. That layer reports three kinds of event as one-cycle strobes: a detected bus reset, with a qualifier that tells a long reset from a short one; each received bit, with its value; and each read slot. For every read slot the block supplies the bit to place on the bus. A value of 1 means the line is released.

After every reset the block collects one command byte. It then reads out its identity code, matches it against a code sent by the master, takes part in a search, or skips addressing altogether. Once the selected command completes, it opens access to the memory-command layer. It also holds the speed-mode flag that the timing layer follows. Two commands set this flag: an overdrive skip and a successful overdrive match. A long reset clears it. The identity code is made from a family parameter and a serial parameter, and the check byte is derived from them at elaboration.

Top module: `ow_rom_layer`

## Requirements
- R1: A command byte is taken from the first eight received bits after a reset, the first bit being bit 0. The codes are 33h read, 55h match, F0h search, CCh skip, 3Ch overdrive skip and 69h overdrive match.
- R2: The identity code holds the family byte (default 0Fh) in bits 7:0, the 48-bit serial in bits 55:8 and the check byte in bits 63:56. The check byte is x^8+x^5+x^4+1 over bits 0..55, bit 0 first, from a zero start, so that all 64 bits leave the register at zero.
- R3: After a read command, the next 64 read slots return the identity bits in order from bit 0, and memory access (mem_en_o=1) is granted after the 64th.
- R4: After a match command, 64 received bits equal to the identity grant memory access. The first differing bit makes the block silent: mem_en_o stays 0 and every read slot returns 1 until the next reset.
- R5: In a search, each identity bit takes three slots: a read returning the bit, a read returning its complement, then a received bit. A received bit that differs drops the block out (silent until reset). Completing all 64 bits grants memory access.
- R6: A skip command grants memory access as soon as its last bit is received.
- R7: An overdrive skip command sets overdrive_o and grants memory access.
- R8: An overdrive match command sets overdrive_o when its command byte completes. A full match keeps the flag set and grants access; a mismatch clears the flag and makes the block silent.
- R9: A long reset clears overdrive_o. A short reset leaves overdrive_o unchanged.
- R10: An unrecognised command byte makes the block silent until the next reset. Later bits and slots have no effect, read slots return 1 and overdrive_o is unchanged.
- R11: Memory access stays granted until the next reset. Every reset drops it, and receipt restarts with a new command byte, even in the middle of a command.
- R12: Outside the identity-transmitting slots of read and search, and whenever memory access is granted, bit_tx_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_det_i | input | 1 | Bus reset detected strobe |
| rst_long_i | input | 1 | Qualifier for rst_det_i: 1 = long (normal-speed) reset |
| bit_rx_i | input | 1 | Received-bit strobe |
| bit_val_i | input | 1 | Value of the received bit |
| slot_req_i | input | 1 | Read-slot strobe; consumes the current bit_tx_o |
| bit_tx_o | output | 1 | Bit to drive in the current read slot (1 = release) |
| overdrive_o | output | 1 | Overdrive speed-mode flag for the timing layer |
| mem_en_o | output | 1 | Memory-command layer enable |

## Verification
The bench builds three instances that all keep the default family byte. Their serials differ only in a few low bits in one pair and in the upper bits in the third. The instances share every input, and their bit outputs are combined as a wired-AND bus. This brings conflicting search slots within reach at several depths, along with dropouts of the losing devices and the one-hot outcome of a match or overdrive match. A full search from the bus side has to find all three codes.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_GRANT,
    ST_IDLE
  } ow_state_e;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, reflected

  function automatic logic [7:0] crc8_body(input logic [55:0] body);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/ow_cmd_rx.sv
module ow_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_en_i,
  input  logic             bit_val_i,
  output logic             done_o,
  output logic [CMD_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;

  // lsb first: newest bit enters at the top
  assign byte_o = {bit_val_i, shreg_q[CMD_W-1:1]};
  assign done_o = bit_en_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
    end else if (bit_en_i) begin
      shreg_q <= byte_o;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ow_id_ptr.sv
module ow_id_ptr #(
  parameter int              ID_W = 64,
  parameter logic [ID_W-1:0] ID   = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic bit_o,
  output logic last_o
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end

  assign bit_o  = ID[idx_q];
  assign last_o = (idx_q == IDX_LAST);

endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
  import ow_rom_pkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h0F,
  parameter logic [47:0] SERIAL = 48'h0000_0000_0001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_det_i,
  input  logic rst_long_i,
  input  logic bit_rx_i,
  input  logic bit_val_i,
  input  logic slot_req_i,
  output logic bit_tx_o,
  output logic overdrive_o,
  output logic mem_en_o
);
  localparam int          FAM_W   = $bits(FAMILY);
  localparam int          SER_W   = $bits(SERIAL);
  localparam int          CHK_W   = 8;
  localparam int          ID_W    = FAM_W + SER_W + CHK_W;
  localparam int          CMD_W   = 8;
  localparam logic [55:0] ID_BODY = {SERIAL, FAMILY};
  localparam logic [7:0]  ID_CHK  = crc8_body(ID_BODY);
  localparam logic [ID_W-1:0] ID  = {ID_CHK, ID_BODY};

  ow_state_e  state_q;
  logic [1:0] phase_q;   // search: 0 true bit, 1 complement, 2 master choice
  logic       od_q;
  logic       odm_q;     // overdrive match in progress

  logic             cmd_en, cmd_done;
  logic [CMD_W-1:0] cmd_byte;
  logic             id_bit, id_last, id_inc;
  logic             bit_ok;

  assign cmd_en = bit_rx_i && !rst_det_i && (state_q == ST_CMD);
  assign bit_ok = (bit_val_i == id_bit);

  always_comb begin
    id_inc = 1'b0;
    unique case (state_q)
      ST_READ:   id_inc = slot_req_i;
      ST_MATCH:  id_inc = bit_rx_i && bit_ok;
      ST_SEARCH: id_inc = bit_rx_i && bit_ok && (phase_q == 2'd2);
      default:   id_inc = 1'b0;
    endcase
  end

  ow_cmd_rx #(.CMD_W(CMD_W)) u_cmd_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rst_det_i),
    .bit_en_i  (cmd_en),
    .bit_val_i (bit_val_i),
    .done_o    (cmd_done),
    .byte_o    (cmd_byte)
  );

  ow_id_ptr #(.ID_W(ID_W), .ID(ID)) u_id_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_det_i),
    .inc_i  (id_inc && !rst_det_i),
    .bit_o  (id_bit),
    .last_o (id_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      phase_q <= 2'd0;
      od_q    <= 1'b0;
      odm_q   <= 1'b0;
    end else if (rst_det_i) begin
      state_q <= ST_CMD;
      phase_q <= 2'd0;
      odm_q   <= 1'b0;
      if (rst_long_i) od_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (cmd_done) begin
          unique case (cmd_byte)
            CMD_READ:     state_q <= ST_READ;
            CMD_MATCH:    state_q <= ST_MATCH;
            CMD_SEARCH: begin
              state_q <= ST_SEARCH;
              phase_q <= 2'd0;
            end
            CMD_SKIP:     state_q <= ST_GRANT;
            CMD_OD_SKIP: begin
              state_q <= ST_GRANT;
              od_q    <= 1'b1;
            end
            CMD_OD_MATCH: begin
              // address bits already arrive at high speed
              state_q <= ST_MATCH;
              od_q    <= 1'b1;
              odm_q   <= 1'b1;
            end
            default:      state_q <= ST_IDLE;
          endcase
        end
        ST_READ: if (slot_req_i && id_last) state_q <= ST_GRANT;
        ST_MATCH: if (bit_rx_i) begin
          if (!bit_ok) begin
            state_q <= ST_IDLE;
            if (odm_q) od_q <= 1'b0;
          end else if (id_last) begin
            state_q <= ST_GRANT;
          end
        end
        ST_SEARCH: begin
          unique case (phase_q)
            2'd0: if (slot_req_i) phase_q <= 2'd1;
            2'd1: if (slot_req_i) phase_q <= 2'd2;
            default: if (bit_rx_i) begin
              phase_q <= 2'd0;
              if (!bit_ok)      state_q <= ST_IDLE;
              else if (id_last) state_q <= ST_GRANT;
            end
          endcase
        end
        default: state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    bit_tx_o = 1'b1;
    if (state_q == ST_READ) begin
      bit_tx_o = id_bit;
    end else if (state_q == ST_SEARCH) begin
      if (phase_q == 2'd0)      bit_tx_o = id_bit;
      else if (phase_q == 2'd1) bit_tx_o = ~id_bit;
    end
  end

  assign overdrive_o = od_q;
  assign mem_en_o    = (state_q == ST_GRANT);

endmodule

// File: rtl/ow_rom_layer_chk.sv
module ow_rom_layer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_det_i,
  input logic rst_long_i,
  input logic bit_rx_i,
  input logic bit_tx_o,
  input logic overdrive_o,
  input logic mem_en_o
);

  p_long_rst_slow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i && rst_long_i |=> !overdrive_o);

  p_short_rst_keeps_od_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i && !rst_long_i && overdrive_o |=> overdrive_o);

  p_rst_drops_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i |=> !mem_en_o);

  p_grant_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !rst_det_i |=> mem_en_o);

  p_grant_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> bit_tx_o);

  // R7 R8: speed mode only rises on a received command bit
  p_od_rise_on_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overdrive_o) |-> $past(bit_rx_i) && !$past(rst_det_i));

endmodule

bind ow_rom_layer ow_rom_layer_chk u_chk (.*);

// File: tb/ow_rom_layer_bench.sv
module ow_rom_layer_bench;
  localparam int N = 3;
  localparam logic [7:0]  FAM  = 8'h0F;
  localparam logic [47:0] SER0 = 48'h3A91_C4E2_0B57;
  localparam logic [47:0] SER1 = 48'h3A91_C4E2_0B5F;
  localparam logic [47:0] SER2 = 48'h0072_D9A1_66C3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rst_det, rst_long, bit_rx, bit_val, slot_req;
  logic [N-1:0] tx, od, mem;

  ow_rom_layer #(.FAMILY(FAM), .SERIAL(SER0)) u_ow_rom_layer (
    .clk_i(clk), .rst_ni(rst_n), .rst_det_i(rst_det), .rst_long_i(rst_long),
    .bit_rx_i(bit_rx), .bit_val_i(bit_val), .slot_req_i(slot_req),
    .bit_tx_o(tx[0]), .overdrive_o(od[0]), .mem_en_o(mem[0]));

  ow_rom_layer #(.FAMILY(FAM), .SERIAL(SER1)) u_peer1 (
    .clk_i(clk), .rst_ni(rst_n), .rst_det_i(rst_det), .rst_long_i(rst_long),
    .bit_rx_i(bit_rx), .bit_val_i(bit_val), .slot_req_i(slot_req),
    .bit_tx_o(tx[1]), .overdrive_o(od[1]), .mem_en_o(mem[1]));

  ow_rom_layer #(.FAMILY(FAM), .SERIAL(SER2)) u_peer2 (
    .clk_i(clk), .rst_ni(rst_n), .rst_det_i(rst_det), .rst_long_i(rst_long),
    .bit_rx_i(bit_rx), .bit_val_i(bit_val), .slot_req_i(slot_req),
    .bit_tx_o(tx[2]), .overdrive_o(od[2]), .mem_en_o(mem[2]));

  int checks = 0;
  int fails  = 0;
  logic [63:0] idv [N];

  function automatic logic [7:0] crc_run(input logic [63:0] v, input int nbits);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < nbits; i++) begin
      fb = c[0] ^ v[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] mk_id(input logic [47:0] s);
    logic [63:0] b;
    b = {8'h00, s, FAM};
    return {crc_run(b, 56), s, FAM};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic bus_reset(input logic is_long);
    @(negedge clk); rst_det = 1'b1; rst_long = is_long;
    @(negedge clk); rst_det = 1'b0; rst_long = 1'b0;
  endtask

  task automatic rx_bit(input logic b);
    @(negedge clk); bit_val = b; bit_rx = 1'b1;
    @(negedge clk); bit_rx = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rx_bit(v[i]);
  endtask

  task automatic rx_id(input logic [63:0] v);
    for (int i = 0; i < 64; i++) rx_bit(v[i]);
  endtask

  task automatic slot(output logic [N-1:0] v);
    @(negedge clk); v = tx; slot_req = 1'b1;
    @(negedge clk); slot_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [N-1:0] v;
    logic [63:0]  got [N];
    logic [63:0]  rom, prev, mis;
    bit           found [N];
    int           k, bp, last, newd, nf;
    bit           dir, done, conflict;

    void'($urandom(32'd1723));
    idv[0] = mk_id(SER0); idv[1] = mk_id(SER1); idv[2] = mk_id(SER2);
    rst_n = 1'b0; rst_det = 1'b0; rst_long = 1'b0;
    bit_rx = 1'b0; bit_val = 1'b0; slot_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(od == '0, "R9 reset state od", 64'(od), 64'd0);
    chk(mem == '0, "R11 reset state mem", 64'(mem), 64'd0);
    chk(tx == '1, "R12 reset state tx", 64'(tx), 64'h7);

    // R3 read identity, R2 layout and check byte
    bus_reset(1'b1);
    rx_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      slot(v);
      for (int g = 0; g < N; g++) got[g][i] = v[g];
    end
    for (int g = 0; g < N; g++) begin
      chk(got[g] == idv[g], "R3 read identity", got[g], idv[g]);
      chk(got[g][7:0] == 8'h0F, "R2 family byte", 64'(got[g][7:0]), 64'h0F);
      chk(crc_run(got[g], 64) == 8'h00, "R2 check byte residue",
          64'(crc_run(got[g], 64)), 64'd0);
    end
    chk(mem == '1, "R3 grant after read", 64'(mem), 64'h7);
    slot(v);
    chk(v == '1, "R12 released after grant", 64'(v), 64'h7);

    // R6 skip, R1 codes
    bus_reset(1'b1);
    rx_byte(8'hCC);
    @(negedge clk);
    chk(mem == '1, "R6 skip grants", 64'(mem), 64'h7);
    chk(od == '0, "R1 skip is not overdrive", 64'(od), 64'd0);

    // R1 bit order: F0h sent msb first reads as 0Fh (unknown) -> R10
    bus_reset(1'b1);
    rx_byte(8'h0F);
    for (int i = 0; i < 8; i++) begin
      slot(v);
      chk(v == '1, "R1 reversed search code is unknown", 64'(v), 64'h7);
    end
    chk(mem == '0, "R1 no grant", 64'(mem), 64'd0);

    // R4 match directed + random
    for (int it = 0; it < 6; it++) begin
      k = int'($urandom % N);
      bus_reset(1'b1);
      rx_byte(8'h55);
      rx_id(idv[k]);
      @(negedge clk);
      chk(mem == N'(1 << k), "R4 match selects one", 64'(mem), 64'(1 << k));
      bp  = int'($urandom % 64);
      mis = idv[k] ^ (64'd1 << bp);
      bus_reset(1'b1);
      rx_byte(8'h55);
      rx_id(mis);
      @(negedge clk);
      slot(v);
      chk(v == '1, "R4 silent after mismatch", 64'(v), 64'h7);
      for (int g = 0; g < N; g++)
        if (idv[g] == mis) chk(1'b0, "R4 corrupted code hit", 64'(g), 64'd0);
      chk(mem == '0, "R4 mismatch no grant", 64'(mem), 64'd0);
    end

    // R7 overdrive skip, R9 short/long resets, R11
    bus_reset(1'b1);
    rx_byte(8'h3C);
    @(negedge clk);
    chk(od == '1, "R7 overdrive skip sets flag", 64'(od), 64'h7);
    chk(mem == '1, "R7 overdrive skip grants", 64'(mem), 64'h7);
    bus_reset(1'b0);
    chk(od == '1, "R9 short reset keeps flag", 64'(od), 64'h7);
    chk(mem == '0, "R11 reset drops grant", 64'(mem), 64'd0);
    rx_byte(8'hCC);
    @(negedge clk);
    chk(mem == '1, "R11 new command after reset", 64'(mem), 64'h7);
    bus_reset(1'b1);
    chk(od == '0, "R9 long reset clears flag", 64'(od), 64'd0);

    // R8 overdrive match
    bus_reset(1'b1);
    rx_byte(8'h69);
    chk(od == '1, "R8 flag set at command", 64'(od), 64'h7);
    rx_id(idv[1]);
    @(negedge clk);
    chk(od == 3'b010, "R8 only matched device stays fast", 64'(od), 64'h2);
    chk(mem == 3'b010, "R8 matched device granted", 64'(mem), 64'h2);
    bus_reset(1'b0);
    chk(od == 3'b010, "R9 short reset in overdrive", 64'(od), 64'h2);
    rx_byte(8'h69);
    rx_id(idv[2] ^ 64'd1);
    @(negedge clk);
    chk(od == '0, "R8 mismatch clears flag", 64'(od), 64'd0);
    chk(mem == '0, "R8 mismatch no grant", 64'(mem), 64'd0);

    // R10 unknown command keeps silence and flag
    bus_reset(1'b1);
    rx_byte(8'h3C);
    bus_reset(1'b0);
    rx_byte(8'hA7);
    rx_byte(8'h33);
    for (int i = 0; i < 8; i++) begin
      slot(v);
      chk(v == '1, "R10 silent after unknown", 64'(v), 64'h7);
    end
    chk(mem == '0, "R10 no grant", 64'(mem), 64'd0);
    chk(od == '1, "R10 flag unchanged", 64'(od), 64'h7);

    // R11 reset mid-read restarts
    bus_reset(1'b1);
    rx_byte(8'h33);
    for (int i = 0; i < 10; i++) slot(v);
    bus_reset(1'b1);
    rx_byte(8'h33);
    slot(v);
    for (int g = 0; g < N; g++)
      chk(v[g] == idv[g][0], "R11 restart at bit 0", 64'(v[g]), 64'(idv[g][0]));

    // R5 search over the wired-AND bus
    for (int g = 0; g < N; g++) found[g] = 1'b0;
    last = -1; prev = '0; nf = 0; done = 1'b0;
    for (int pass = 0; pass < N + 1 && !done; pass++) begin
      logic [N-1:0] a, b;
      bus_reset(1'b1);
      rx_byte(8'hF0);
      rom = '0; newd = -1; conflict = 1'b0;
      for (int i = 0; i < 64 && !conflict; i++) begin
        slot(a);
        slot(b);
        if (pass == 0 && i == 0)
          for (int g = 0; g < N; g++) begin
            chk(a[g] == idv[g][0], "R5 true bit", 64'(a[g]), 64'(idv[g][0]));
            chk(b[g] == ~idv[g][0], "R5 complement bit", 64'(b[g]), 64'(~idv[g][0]));
          end
        if ((&a) && (&b)) begin
          chk(1'b0, "R5 no responder", 64'(i), 64'd0);
          conflict = 1'b1;
        end else begin
          if ((&a) != (&b)) dir = &a;
          else begin
            if (i < last) dir = prev[i];
            else          dir = (i == last);
            if (!dir) newd = i;
          end
          rx_bit(dir);
          rom[i] = dir;
        end
      end
      @(negedge clk);
      k = -1;
      for (int g = 0; g < N; g++) if (idv[g] == rom) k = g;
      chk(k >= 0, "R5 search result is a device", rom, 64'd0);
      if (k >= 0) begin
        chk(mem == N'(1 << k), "R5 only winner granted", 64'(mem), 64'(1 << k));
        if (!found[k]) nf++;
        found[k] = 1'b1;
      end
      prev = rom; last = newd;
      if (last < 0) done = 1'b1;
    end
    chk(nf == N, "R5 all devices found", 64'(nf), 64'(N));

    // mixed random traffic
    for (int it = 0; it < 12; it++) begin
      k = int'($urandom % N);
      bus_reset(1'b1);
      case ($urandom % 3)
        0: begin
          rx_byte(8'hCC);
          @(negedge clk);
          chk(mem == '1, "R6 random skip", 64'(mem), 64'h7);
        end
        1: begin
          rx_byte(8'h55);
          rx_id(idv[k]);
          @(negedge clk);
          chk(mem == N'(1 << k), "R4 random match", 64'(mem), 64'(1 << k));
        end
        default: begin
          rx_byte(8'h33);
          for (int i = 0; i < 64; i++) begin
            slot(v);
            got[k][i] = v[k];
          end
          chk(got[k] == idv[k], "R3 random read", got[k], idv[k]);
        end
      endcase
    end

    finish_run();
  end

endmodule